// File: doc/BRIEF.md
# BCD Seven-Segment Display Decoder

This block converts one binary-coded decimal digit into the seven drive levels for segments a through g of a numeric display. Valid digits 0 to 9 light the familiar numeral shapes. The six codes that are not decimal digits turn every segment off. The default build drives a common-anode display, where a segment is lit by a logic 0. A build parameter inverts every output for a common-cathode display, where a segment is lit by a logic 1.

Two controls extend the basic decode. A lamp-test input lights every segment so that a missing segment is easy to spot. A zero-blank input and a zero-blank output can be chained from the most significant digit towards the least significant. This suppresses leading zeros across a row of digits: each decoder blanks a zero only when every digit to its left was also a blanked zero. The block is purely combinational and has no clock or reset. Digit scanning, current limiting and the display itself belong outside it.

Top module: `bcd_seg7_decoder`

## Requirements
- R1: With the default polarity and no control input active, codes 0, 1, 2 and 3 drive seg_o to 7'b0000001, 7'b1001111, 7'b0010010 and 7'b0000110.
- R2: With the default polarity and no control input active, codes 4 to 9 drive seg_o to 7'b1001100, 7'b0100100, 7'b0100000, 7'b0001111, 7'b0000000 and 7'b0000100. The 6 and the 9 are drawn with tails.
- R3: Any code from 10 to 15 turns all seven segments off: 7'b1111111 with the default polarity.
- R4: seg_o[6] drives segment a and seg_o[0] drives segment g, with b, c, d, e and f on bits 5 down to 1. For example, code 1 lights only bits 5 and 4.
- R5: In the default build (COMMON_CATHODE = 0) the outputs are active low: a 0 lights a segment and a 1 leaves it dark.
- R6: With COMMON_CATHODE = 1, every seg_o bit is the inverse of its default-build value for the same inputs. The outputs are then active high.
- R7: When lamp_test_i is 1, every segment is lit, whatever the code and the zero-blank input.
- R8: When zero_blank_i is 1 and the code is 0, all segments are off (unless lamp test is active) and zero_blank_o is 1.
- R9: zero_blank_o is 0 in every other case, including code 0 with zero_blank_i at 0, which displays a normal 0. The zero-blank input has no effect on codes 1 to 15. zero_blank_o does not depend on lamp_test_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_i | input | 4 | Digit code, 0 to 9 valid |
| lamp_test_i | input | 1 | 1 lights every segment |
| zero_blank_i | input | 1 | 1 requests that a 0 digit be blanked |
| seg_o | output | 7 | Segment drive, a on bit 6 to g on bit 0 |
| zero_blank_o | output | 1 | 1 when this digit was a blanked zero |

## Verification
Every result is due in the same time step as the input change, because no register lies between any input and either output. The bench therefore has no latency to count. It changes inputs just after a rising edge of its pacing clock and samples both outputs at the following falling edge, when the decode has long settled. A default-polarity instance and a common-cathode instance are driven with the same inputs and checked side by side, against expected values taken from a table of digit shapes held in the bench.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int DIGIT_W   = 4;
  localparam int SEG_W     = 7;
  localparam int LAST_DEC  = 9;

  typedef logic [SEG_W-1:0]   seg_vec_t;
  typedef logic [DIGIT_W-1:0] digit_t;

  // Bit index of each segment inside a seg_vec_t
  typedef enum int {
    SEG_G = 0, SEG_F = 1, SEG_E = 2, SEG_D = 3,
    SEG_C = 4, SEG_B = 5, SEG_A = 6
  } seg_idx_e;

  localparam seg_vec_t ALL_LIT  = '1;
  localparam seg_vec_t ALL_DARK = '0;

  // Build a lit-mask (1 = lit) from a list of segment flags
  function automatic seg_vec_t lit_mask(input bit a, input bit b, input bit c,
                                        input bit d, input bit e, input bit f,
                                        input bit g);
    seg_vec_t m;
    m = '0;
    m[SEG_A] = a; m[SEG_B] = b; m[SEG_C] = c; m[SEG_D] = d;
    m[SEG_E] = e; m[SEG_F] = f; m[SEG_G] = g;
    return m;
  endfunction
endpackage

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
  import seg7_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [SEG_W-1:0]   lit_o,
  output logic               valid_o
);
  always_comb begin
    valid_o = (int'(digit_i) <= LAST_DEC);
    unique case (digit_i)
      4'd0:    lit_o = lit_mask(1, 1, 1, 1, 1, 1, 0);
      4'd1:    lit_o = lit_mask(0, 1, 1, 0, 0, 0, 0);
      4'd2:    lit_o = lit_mask(1, 1, 0, 1, 1, 0, 1);
      4'd3:    lit_o = lit_mask(1, 1, 1, 1, 0, 0, 1);
      4'd4:    lit_o = lit_mask(0, 1, 1, 0, 0, 1, 1);
      4'd5:    lit_o = lit_mask(1, 0, 1, 1, 0, 1, 1);
      4'd6:    lit_o = lit_mask(1, 0, 1, 1, 1, 1, 1);
      4'd7:    lit_o = lit_mask(1, 1, 1, 0, 0, 0, 0);
      4'd8:    lit_o = lit_mask(1, 1, 1, 1, 1, 1, 1);
      4'd9:    lit_o = lit_mask(1, 1, 1, 1, 0, 1, 1);
      default: lit_o = ALL_DARK;
    endcase
  end

  // R2: every decimal glyph lights at least two segments; others light none
  always_comb begin
    if (valid_o)
      a_r2_glyph_min_lit: assert ($countones(lit_o) >= 2)
        else $error("R2 glyph too sparse");
    else
      a_r3_nondec_dark: assert (lit_o == ALL_DARK)
        else $error("R3 non-decimal code lights a segment");
  end
endmodule

// File: rtl/seg7_blank_ctrl.sv
module seg7_blank_ctrl
  import seg7_pkg::*;
(
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic [SEG_W-1:0]   glyph_i,
  input  logic               lamp_test_i,
  input  logic               zero_blank_i,
  output logic [SEG_W-1:0]   lit_o,
  output logic               zero_blank_o
);
  logic is_zero;
  logic suppress;

  always_comb begin
    is_zero      = (digit_i == '0);
    suppress     = zero_blank_i & is_zero;
    zero_blank_o = suppress;
    if (lamp_test_i)   lit_o = ALL_LIT;
    else if (suppress) lit_o = ALL_DARK;
    else               lit_o = glyph_i;
  end

  // R7: lamp test lights everything
  always_comb begin
    if (lamp_test_i)
      a_r7_lamp_all_lit: assert (lit_o == ALL_LIT)
        else $error("R7 lamp test not all lit");
  end

  // R9: with no control active, the glyph passes through untouched
  always_comb begin
    if (!lamp_test_i && !zero_blank_o)
      a_r9_pass_glyph: assert (lit_o == glyph_i)
        else $error("R9 glyph altered without cause");
  end
endmodule

// File: rtl/seg7_pol_drv.sv
module seg7_pol_drv
  import seg7_pkg::*;
#(
  parameter bit COMMON_CATHODE = 1'b0
) (
  input  logic [SEG_W-1:0] lit_i,
  output logic [SEG_W-1:0] seg_o
);
  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    if (COMMON_CATHODE) begin : g_high
      assign seg_o[s] = lit_i[s];
    end else begin : g_low
      assign seg_o[s] = ~lit_i[s];
    end
  end
endmodule

// File: rtl/bcd_seg7_decoder.sv
module bcd_seg7_decoder
  import seg7_pkg::*;
#(
  parameter bit COMMON_CATHODE = 1'b0
) (
  input  logic [3:0] bcd_i,
  input  logic       lamp_test_i,
  input  logic       zero_blank_i,
  output logic [6:0] seg_o,
  output logic       zero_blank_o
);
  localparam seg_vec_t SEG_ON  = COMMON_CATHODE ? ALL_LIT  : ALL_DARK;
  localparam seg_vec_t SEG_OFF = COMMON_CATHODE ? ALL_DARK : ALL_LIT;

  seg_vec_t glyph;
  seg_vec_t lit;
  logic     glyph_valid;

  seg7_glyph_rom u_rom (
    .digit_i (bcd_i),
    .lit_o   (glyph),
    .valid_o (glyph_valid)
  );

  seg7_blank_ctrl u_blank (
    .digit_i      (bcd_i),
    .glyph_i      (glyph),
    .lamp_test_i  (lamp_test_i),
    .zero_blank_i (zero_blank_i),
    .lit_o        (lit),
    .zero_blank_o (zero_blank_o)
  );

  seg7_pol_drv #(.COMMON_CATHODE(COMMON_CATHODE)) u_drv (
    .lit_i (lit),
    .seg_o (seg_o)
  );

  // Port-level checks across the three stages
  always_comb begin
    if (lamp_test_i)
      a_r7_port_all_on: assert (seg_o == SEG_ON)
        else $error("R7 lamp test at port");
    if (!lamp_test_i && zero_blank_o)
      a_r8_blank_dark: assert (seg_o == SEG_OFF)
        else $error("R8 blanked zero still lit");
    if (!lamp_test_i && !glyph_valid)
      a_r3_port_dark: assert (seg_o == SEG_OFF)
        else $error("R3 non-decimal code at port");
    if (zero_blank_o)
      a_r9_rbo_only_zero: assert (bcd_i == 4'd0 && zero_blank_i)
        else $error("R9 zero-blank out without cause");
  end
endmodule

// File: tb/test_bcd_seg7_decoder.sv
module test_bcd_seg7_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz pacing clock

  logic [3:0] bcd;
  logic       lt, rbi;
  logic [6:0] seg_ca, seg_cc;
  logic       rbo_ca, rbo_cc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bcd_seg7_decoder i_bcd_seg7_decoder (
    .bcd_i(bcd), .lamp_test_i(lt), .zero_blank_i(rbi),
    .seg_o(seg_ca), .zero_blank_o(rbo_ca));

  bcd_seg7_decoder #(.COMMON_CATHODE(1'b1)) i_bcd_seg7_decoder_cc (
    .bcd_i(bcd), .lamp_test_i(lt), .zero_blank_i(rbi),
    .seg_o(seg_cc), .zero_blank_o(rbo_cc));

  // Expected common-anode shapes, a in the MSB
  function automatic logic [6:0] shape_ca(input logic [3:0] v);
    case (v)
      4'd0: return 7'b0000001;  4'd1: return 7'b1001111;
      4'd2: return 7'b0010010;  4'd3: return 7'b0000110;
      4'd4: return 7'b1001100;  4'd5: return 7'b0100100;
      4'd6: return 7'b0100000;  4'd7: return 7'b0001111;
      4'd8: return 7'b0000000;  4'd9: return 7'b0000100;
      default: return 7'b1111111;
    endcase
  endfunction

  function automatic logic [6:0] exp_ca(input logic [3:0] v, input logic l, input logic r);
    if (l) return 7'b0000000;
    if (r && v == 4'd0) return 7'b1111111;
    return shape_ca(v);
  endfunction

  function automatic string tag_of(input logic [3:0] v, input logic l, input logic r);
    if (l) return "R7";
    if (r && v == 4'd0) return "R8";
    if (v > 4'd9) return "R3";
    if (v < 4'd4) return "R1";
    return "R2";
  endfunction

  task automatic chk7(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s bcd=%0d lt=%0b rbi=%0b act=%b exp=%b", req, bcd, lt, rbi, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s bcd=%0d lt=%0b rbi=%0b act=%b exp=%b", req, bcd, lt, rbi, act, exp);
    end
  endtask

  // Drive after a rising edge, sample at the next falling edge
  task automatic apply(input logic [3:0] v, input logic l, input logic r);
    @(posedge clk); #0.5;
    bcd = v; lt = l; rbi = r;
    @(negedge clk);
    chk7(tag_of(v, l, r), seg_ca, exp_ca(v, l, r));
    chk7("R6", seg_cc, ~exp_ca(v, l, r));
    chk1((r && v == 4'd0) ? "R8" : "R9", rbo_ca, r && v == 4'd0);
    chk1("R9", rbo_cc, r && v == 4'd0);
  endtask

  initial begin
    bcd = '0; lt = 1'b0; rbi = 1'b0;
    @(negedge clk);
    // Idle state: code 0 with no control shows a zero
    chk7("R1", seg_ca, 7'b0000001);
    chk1("R9", rbo_ca, 1'b0);

    // Directed: every code plain
    for (int v = 0; v < 16; v++) apply(4'(v), 1'b0, 1'b0);
    // R4: code 1 lights only b (bit 5) and c (bit 4)
    apply(4'd1, 1'b0, 1'b0);
    chk7("R4", ~seg_ca, 7'b0110000);
    // R5: code 8 drives every output low by default
    apply(4'd8, 1'b0, 1'b0);
    chk7("R5", seg_ca, 7'b0000000);
    // R8 / R9 ripple blanking corners
    apply(4'd0, 1'b0, 1'b1);
    apply(4'd5, 1'b0, 1'b1);
    apply(4'd12, 1'b0, 1'b1);
    apply(4'd0, 1'b1, 1'b1);   // lamp test wins, rbo still follows zero
    // R7 lamp test over every code
    for (int v = 0; v < 16; v++) apply(4'(v), 1'b1, 1'(v & 1));

    // Random stimulus, fixed seed
    void'($urandom(32'h5e9a_11c3));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom();
      apply(r[3:0], (r[7:4] == 4'd0), r[8]);
    end

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule